// File: doc/BRIEF.md
# Dual-Word Ethernet Transmit Lane Packer

The packer sits between a frame source that produces one 64-bit word per beat and a transmit MAC client bus that moves two 64-bit words per clock. Each input word carries valid, start and end flags, a count of invalid trailing bytes, and an error flag. The input follows valid/ready rules: a word is transferred on a cycle where both `in_valid` and `in_ready` are high, and the source must hold the word steady while `in_ready` is low. The MAC side has no valid signal: each lane carries its own idle flag. A beat with data counts as consumed only on a cycle where the MAC raises `tx_accept`. Until then the packer holds every output field unchanged.

Words are packed in arrival order. The older word goes to the upper lane (bits [127:64]) and the newer word to the lower lane (bits [63:0]). Bytes are big-endian within each word, so a frame always starts on a word boundary and may end on any byte. Lanes are independent, so one frame can close in the upper lane while the next one opens in the lower lane of the same beat. A frame of one word is at most eight bytes long, which is a runt. Any input word flagged as both start and end is accepted and then discarded, so the MAC never sees it. If no second word arrives, a word waiting for a partner is not held indefinitely. It leaves at the next chance, with the lower lane idle.

Top module: `eth_tx_lane_packer`

## Requirements
- R1: After a synchronous active-high reset, both lanes are idle (`tx_idle` = 2'b11), no start, end or error flag is set, and `in_ready` is high.
- R2: When a beat carries two words, the word accepted earlier sits in bits [127:64] (lane 1) and the later word in bits [63:0] (lane 0). Every word reaches the output with its 64 data bits unchanged.
- R3: `tx_sop[z]` is set exactly when lane z holds the first word of a frame. Bit 0 refers to bits [63:0] and bit 1 refers to bits [127:64].
- R4: `tx_eop[z]` marks the last word of a frame, and `tx_empty[3z+2:3z]` gives its count of invalid trailing bytes (0 to 7). A lane whose end flag is clear shows an empty count of 0. Example: a frame ending in lane 1 with two valid bytes, and no other end in the beat, gives `tx_eop` = 2'b10 and `tx_empty` = 6'b110_000.
- R5: `tx_err[z]` is set only when `tx_eop[z]` is set and the input error flag was high on that frame's last word. An error flag on any other word has no effect.
- R6: A lane that holds no frame word has its `tx_idle` bit set, its data bits at zero, and its start, end, empty and error fields clear.
- R7: An input word with both start and end set is accepted (it is consumed with `in_ready`) and never appears on the output.
- R8: While a beat with data is presented and `tx_accept` is low, all output fields stay stable. `in_ready` is low whenever a word is also waiting in the hold register.
- R9: If a beat is loaded while an input word transfers, that word takes the lower lane of the new beat. This includes a start word arriving just after a frame ended in the upper lane.
- R10: A waiting word is released at the first cycle the output slot is free, even if no partner word has arrived. The lower lane is then idle, and the lower lane is never filled while the upper lane is idle.
- R11: A reset in the middle of a frame discards the held word and the presented beat, and returns to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 64 | Input word, big-endian bytes |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | Input word is the first of a frame |
| in_eop | input | 1 | Input word is the last of a frame |
| in_empty | input | 3 | Invalid trailing bytes in an end word |
| in_err | input | 1 | Mark the frame as bad (used on the end word) |
| in_ready | output | 1 | Packer can take the input word this cycle |
| tx_data | output | 128 | Two words, older in [127:64] |
| tx_sop | output | 2 | Per-lane frame start |
| tx_eop | output | 2 | Per-lane frame end |
| tx_empty | output | 6 | Per-lane invalid byte count, lane z in [3z+2:3z] |
| tx_idle | output | 2 | Per-lane idle marker |
| tx_err | output | 2 | Per-lane error on the end word |
| tx_accept | input | 1 | MAC consumes the presented beat |

## Verification
Back-to-back frames at full rate with `tx_accept` held high show whether lanes are filled in the right order. They also show whether an end in the upper lane and a start in the lower lane can share a beat. A sparse source with a generous MAC leaves words without partners, which separates a packer that releases lone words from one that waits. Long periods with `tx_accept` mostly low exercise output hold and the `in_ready` stall. Single-word runts mixed between real frames, and garbage empty and error bits on middle words, show whether runts are dropped and whether the per-lane fields are gated by the end flag. A reset in the middle of a frame, with a word held, checks that nothing partial survives.

// File: rtl/txp_pkg.sv
package txp_pkg;
  localparam int WORD_W  = 64;
  localparam int LANES   = 2;
  localparam int BYTES   = WORD_W / 8;
  localparam int EMPTY_W = $clog2(BYTES);
  localparam int BUS_W   = WORD_W * LANES;
  localparam int UPPER   = LANES - 1;
  localparam int LOWER   = 0;

  typedef struct packed {
    logic               err;
    logic [EMPTY_W-1:0] empty;
    logic               eop;
    logic               sop;
    logic [WORD_W-1:0]  data;
  } word_t;

  localparam word_t WORD_NONE = '0;
endpackage

// File: rtl/txp_runt_gate.sv
// Classifies the input word: qualifies the transfer, drops single-word
// frames and clears the end-only fields on words that do not end a frame.
module txp_runt_gate
  import txp_pkg::*;
(
  input  logic               fire,
  input  logic [WORD_W-1:0]  data,
  input  logic               sop,
  input  logic               eop,
  input  logic [EMPTY_W-1:0] empty,
  input  logic               err,
  output logic               take,
  output word_t              word
);
  logic runt;

  always_comb begin
    runt       = sop && eop;
    take       = fire && !runt;
    word.data  = data;
    word.sop   = sop;
    word.eop   = eop;
    word.empty = eop ? empty : '0;
    word.err   = eop && err;
  end
endmodule

// File: rtl/txp_hold.sv
// Single-word hold register: keeps a word that is waiting for a lane.
module txp_hold
  import txp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  drain,
  input  word_t d,
  output word_t q,
  output logic  vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      q   <= WORD_NONE;
    end else if (load) begin
      vld <= 1'b1;
      q   <= d;
    end else if (drain) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/txp_beat.sv
// Output beat register: one word slot and one occupancy bit per lane.
module txp_beat
  import txp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             release_beat,
  input  word_t            lane_d [LANES],
  input  logic [LANES-1:0] used_d,
  output word_t            lane_q [LANES],
  output logic [LANES-1:0] used_q
);
  for (genvar z = 0; z < LANES; z++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        used_q[z] <= 1'b0;
        lane_q[z] <= WORD_NONE;
      end else if (load) begin
        used_q[z] <= used_d[z];
        lane_q[z] <= used_d[z] ? lane_d[z] : WORD_NONE;
      end else if (release_beat) begin
        used_q[z] <= 1'b0;
        lane_q[z] <= WORD_NONE;
      end
    end
  end
endmodule

// File: rtl/txp_lane_out.sv
// Maps the lane slots onto the flat per-lane client bus fields.
module txp_lane_out
  import txp_pkg::*;
(
  input  word_t                    lane_q [LANES],
  input  logic [LANES-1:0]         used_q,
  output logic [BUS_W-1:0]         data,
  output logic [LANES-1:0]         sop,
  output logic [LANES-1:0]         eop,
  output logic [LANES*EMPTY_W-1:0] empty,
  output logic [LANES-1:0]         idle,
  output logic [LANES-1:0]         err
);
  for (genvar z = 0; z < LANES; z++) begin : g_lane
    always_comb begin
      data[z*WORD_W +: WORD_W]    = used_q[z] ? lane_q[z].data : '0;
      sop[z]                      = used_q[z] && lane_q[z].sop;
      eop[z]                      = used_q[z] && lane_q[z].eop;
      empty[z*EMPTY_W +: EMPTY_W] = (used_q[z] && lane_q[z].eop) ? lane_q[z].empty : '0;
      err[z]                      = used_q[z] && lane_q[z].eop && lane_q[z].err;
      idle[z]                     = !used_q[z];
    end
  end
endmodule

// File: rtl/eth_tx_lane_packer.sv
module eth_tx_lane_packer
  import txp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WORD_W-1:0]        in_data,
  input  logic                     in_valid,
  input  logic                     in_sop,
  input  logic                     in_eop,
  input  logic [EMPTY_W-1:0]       in_empty,
  input  logic                     in_err,
  output logic                     in_ready,
  output logic [BUS_W-1:0]         tx_data,
  output logic [LANES-1:0]         tx_sop,
  output logic [LANES-1:0]         tx_eop,
  output logic [LANES*EMPTY_W-1:0] tx_empty,
  output logic [LANES-1:0]         tx_idle,
  output logic [LANES-1:0]         tx_err,
  input  logic                     tx_accept
);
  logic             slot_free, fire, take, publish;
  logic             hold_v, hold_load;
  word_t            in_word, hold_q;
  word_t            lane_d [LANES];
  word_t            lane_q [LANES];
  logic [LANES-1:0] used_d, used_q;

  // The slot is free when empty or when the MAC takes the current beat.
  always_comb begin
    slot_free = (used_q == '0) || tx_accept;
    in_ready  = !hold_v || slot_free;
    fire      = in_valid && in_ready;
    publish   = slot_free && hold_v;
    hold_load = take && !publish;
  end

  txp_runt_gate u_gate (
    .fire  (fire),
    .data  (in_data),
    .sop   (in_sop),
    .eop   (in_eop),
    .empty (in_empty),
    .err   (in_err),
    .take  (take),
    .word  (in_word)
  );

  txp_hold u_hold (
    .clk   (clk),
    .rst   (rst),
    .load  (hold_load),
    .drain (publish),
    .d     (in_word),
    .q     (hold_q),
    .vld   (hold_v)
  );

  // The held (older) word fills the upper lane; a word transferring now
  // fills the lower lane.
  always_comb begin
    lane_d[UPPER] = hold_q;
    lane_d[LOWER] = in_word;
    used_d        = '0;
    used_d[UPPER] = 1'b1;
    used_d[LOWER] = take;
  end

  txp_beat u_beat (
    .clk          (clk),
    .rst          (rst),
    .load         (publish),
    .release_beat (tx_accept),
    .lane_d       (lane_d),
    .used_d       (used_d),
    .lane_q       (lane_q),
    .used_q       (used_q)
  );

  txp_lane_out u_out (
    .lane_q (lane_q),
    .used_q (used_q),
    .data   (tx_data),
    .sop    (tx_sop),
    .eop    (tx_eop),
    .empty  (tx_empty),
    .idle   (tx_idle),
    .err    (tx_err)
  );
endmodule

// File: rtl/txp_checker.sv
module txp_checker (
  input logic         clk,
  input logic         rst,
  input logic         in_ready,
  input logic         hold_v,
  input logic [127:0] tx_data,
  input logic [1:0]   tx_sop,
  input logic [1:0]   tx_eop,
  input logic [5:0]   tx_empty,
  input logic [1:0]   tx_idle,
  input logic [1:0]   tx_err,
  input logic         tx_accept
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (tx_idle == 2'b11 && tx_sop == 2'b00 && in_ready)); // R1

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (tx_idle & (tx_sop | tx_eop | tx_err)) == 2'b00); // R6

  AST_ERR_ON_END: assert property (@(posedge clk) disable iff (rst)
    (tx_err & ~tx_eop) == 2'b00); // R5

  AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (rst)
    !tx_eop[0] |-> tx_empty[2:0] == 3'd0); // R4

  AST_EMPTY_HIGH: assert property (@(posedge clk) disable iff (rst)
    !tx_eop[1] |-> tx_empty[5:3] == 3'd0); // R4

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
    (tx_sop & tx_eop) == 2'b00); // R7

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
    (tx_idle != 2'b11 && !tx_accept) |=>
      ($stable(tx_data) && $stable(tx_sop) && $stable(tx_eop) &&
       $stable(tx_empty) && $stable(tx_err) && $stable(tx_idle))); // R8

  AST_STALL_READY: assert property (@(posedge clk) disable iff (rst)
    (hold_v && tx_idle != 2'b11 && !tx_accept) |-> !in_ready); // R8

  AST_UPPER_FIRST: assert property (@(posedge clk) disable iff (rst)
    !tx_idle[0] |-> !tx_idle[1]); // R10
endmodule

bind eth_tx_lane_packer txp_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .hold_v    (hold_v),
  .tx_data   (tx_data),
  .tx_sop    (tx_sop),
  .tx_eop    (tx_eop),
  .tx_empty  (tx_empty),
  .tx_idle   (tx_idle),
  .tx_err    (tx_err),
  .tx_accept (tx_accept)
);

// File: tb/eth_tx_lane_packer_tb.sv
module eth_tx_lane_packer_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [63:0]  in_data = '0;
  logic         in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [2:0]   in_empty = '0;
  logic         in_ready;
  logic [127:0] tx_data;
  logic [1:0]   tx_sop, tx_eop, tx_idle, tx_err;
  logic [5:0]   tx_empty;
  logic         tx_accept = 1'b0;

  always #4 clk = ~clk;

  eth_tx_lane_packer u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_err(in_err),
    .in_ready(in_ready), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_empty(tx_empty), .tx_idle(tx_idle), .tx_err(tx_err), .tx_accept(tx_accept)
  );

  // Word record: {err, empty[2:0], eop, sop, data[63:0]}
  logic [69:0] src_q[$];
  int checks = 0, fails = 0;
  int frames_sent = 0, sops_seen = 0;
  int saw_pack = 0, saw_half = 0, saw_example = 0;

  // Reference state
  bit          m_hv, m_full, m_lov;
  logic [69:0] m_h, m_u, m_l;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [69:0] norm(logic [69:0] w);
    return w[65] ? w : {4'b0, w[65:0]};
  endfunction

  task automatic add_frame(int n, int emp, bit e);
    for (int i = 0; i < n; i++) begin
      logic [69:0] w;
      w[63:0] = {$urandom, $urandom};
      w[64]   = (i == 0);
      w[65]   = (i == n - 1);
      w[68:66] = (i == n - 1) ? emp[2:0] : 3'($urandom);
      w[69]   = (i == n - 1) ? e : 1'($urandom);
      src_q.push_back(w);
    end
    if (n >= 2) frames_sent++;
  endtask

  task automatic compare();
    logic [127:0] ed;
    logic [1:0]   es, ee, ei, er;
    logic [5:0]   em;
    bit uv, lv;
    uv = m_full;
    lv = m_full && m_lov;
    ed = {uv ? m_u[63:0] : 64'h0, lv ? m_l[63:0] : 64'h0};
    es = {uv && m_u[64], lv && m_l[64]};
    ee = {uv && m_u[65], lv && m_l[65]};
    em = {(uv && m_u[65]) ? m_u[68:66] : 3'd0, (lv && m_l[65]) ? m_l[68:66] : 3'd0};
    er = {uv && m_u[65] && m_u[69], lv && m_l[65] && m_l[69]};
    ei = {!uv, !lv};
    chk(tx_data == ed, "R2 data lanes", tx_data, ed);
    chk(tx_sop == es, "R3 sop", 128'(tx_sop), 128'(es));
    chk(tx_eop == ee && tx_empty == em, "R4 eop/empty", 128'({tx_eop, tx_empty}), 128'({ee, em}));
    chk(tx_err == er, "R5 err", 128'(tx_err), 128'(er));
    chk(tx_idle == ei, "R6 idle", 128'(tx_idle), 128'(ei));
    if (tx_eop[1] && tx_sop[0]) saw_pack++;
    if (uv && !lv) saw_half++;
    if (tx_eop == 2'b10 && tx_empty == 6'b110_000) saw_example++;
  endtask

  // One cycle: compare at negedge, drive, check ready, advance model.
  task automatic step(int vp, int ap);
    bit m_free, m_ready, fire, take;
    logic [69:0] w;
    @(negedge clk);
    if (!rst) compare();
    in_valid  = (src_q.size() > 0) && (($urandom % 100) < vp);
    w         = (src_q.size() > 0) ? src_q[0] : '0;
    in_data   = w[63:0];
    in_sop    = w[64];
    in_eop    = w[65];
    in_empty  = w[68:66];
    in_err    = w[69];
    tx_accept = (($urandom % 100) < ap);
    #1;
    if (rst) begin
      m_hv = 0; m_full = 0; m_lov = 0;
      return;
    end
    m_free  = !m_full || tx_accept;
    m_ready = !m_hv || m_free;
    chk(in_ready == m_ready, "R8 in_ready", 128'(in_ready), 128'(m_ready));
    if (tx_accept && m_full) sops_seen += $countones(tx_sop & ~tx_idle);
    fire = in_valid && m_ready;
    take = fire && !(w[64] && w[65]);
    if (fire) void'(src_q.pop_front());
    if (m_free && m_hv) begin
      m_u = m_h; m_full = 1; m_lov = take;
      m_l = take ? norm(w) : '0;
      m_hv = 0;
    end else begin
      if (m_free) m_full = 0;
      if (take) begin
        m_h = norm(w); m_hv = 1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_hv = 0; m_full = 0; m_lov = 0; m_h = '0; m_u = '0; m_l = '0;
    repeat (3) step(0, 0);
    rst = 1'b0;
    #2;
    chk(tx_idle == 2'b11 && tx_sop == 0 && tx_eop == 0 && tx_err == 0 && in_ready,
        "R1 reset state", 128'({tx_idle, tx_sop, tx_eop, tx_err, in_ready}), 128'({2'b11, 7'b0000001}));
    // Back-to-back frames at full rate: R9 packing, R4 example field.
    add_frame(3, 6, 0);
    add_frame(2, 0, 1);
    add_frame(4, 3, 0);
    repeat (30) step(100, 100);
    // Runts between frames, R7.
    for (int i = 0; i < 20; i++) add_frame(($urandom % 3) + 1, $urandom % 8, 1'($urandom));
    repeat (200) step(100, 100);
    // Sparse source, R10 lone words.
    for (int i = 0; i < 30; i++) add_frame(($urandom % 4) + 1, $urandom % 8, 1'($urandom));
    repeat (600) step(20, 100);
    // Heavy backpressure, R8 hold.
    for (int i = 0; i < 40; i++) add_frame(($urandom % 5) + 1, $urandom % 8, 1'($urandom));
    repeat (1500) step(100, 10);
    // Mixed random traffic.
    for (int i = 0; i < 200; i++) add_frame(($urandom % 6) + 1, $urandom % 8, 1'($urandom));
    repeat (4000) step(70, 60);
    // Drain everything.
    for (int i = 0; i < 2000 && (src_q.size() > 0 || m_hv || m_full); i++) step(100, 100);
    repeat (4) step(0, 100);
    chk(sops_seen == frames_sent, "R7 runts dropped, frames delivered", 128'(sops_seen), 128'(frames_sent));
    chk(saw_pack > 0, "R9 end upper and start lower in one beat", 128'(saw_pack), 128'(1));
    chk(saw_half > 0, "R10 lone word released with idle lower lane", 128'(saw_half), 128'(1));
    chk(saw_example > 0, "R4 upper end with empty 6", 128'(saw_example), 128'(1));
    // Mid-frame reset, R11.
    add_frame(5, 2, 0);
    repeat (3) step(100, 0);
    rst = 1'b1;
    repeat (2) step(0, 0);
    src_q.delete();
    rst = 1'b0;
    @(negedge clk);
    #2;
    chk(tx_idle == 2'b11 && tx_sop == 0 && tx_eop == 0 && in_ready,
        "R11 mid-frame reset", 128'({tx_idle, tx_sop, tx_eop, in_ready}), 128'({2'b11, 5'b00001}));
    repeat (5) step(100, 100);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule